// File: doc/BRIEF.md
# Clipped Pixel Address Generator

This block sits between a geometry plotter and a frame memory controller. The plotter delivers one pixel per command: a signed X/Y coordinate and a colour. The block first tests the pixel against a programmable clip window. A pixel outside the window is discarded and causes no memory traffic. A pixel inside the window becomes a write request that carries a full 32-bit word-aligned memory address, the bit position of the pixel inside that 16-bit word, and the colour. The read-modify-write of sub-byte pixels is left to the memory side.

Software programs the block through a small register write port. The port sets four values: a compact bitmap origin, the bitmap row pitch in pixels, the clip maxima and the colour depth. The origin is kept in units of 256 bytes, so a short register can still place a bitmap anywhere in a 4 GiB space. The clip window protects code and data that share the same memory from careless drawing. The input and output both use valid/ready handshakes. The datapath is a two-stage pipeline that accepts one pixel per clock while the consumer keeps up.

Top module: `pixel_addr_gen`

## Requirements
- R1: The byte address of a pixel is the 24-bit origin register times 256 plus the byte offset of the pixel, computed modulo 2^32. The result is a full 32-bit address, and addresses above 2^20 are reached without wrapping.
- R2: At 8 bits per pixel (depth field 0), the byte offset is Y times the pitch plus X, and the colour passes through unchanged.
- R3: At 4 bits per pixel (depth field 1), the bit offset is (Y times the pitch plus X) times 4. The byte offset is that bit offset divided by 8, rounded down.
- R4: Bit 0 of outAddr is always 0. outBitSel is the bit offset of the pixel modulo 16. It is therefore 0 or 8 at 8 bits per pixel, and 0, 4, 8 or 12 at 4 bits per pixel.
- R5: A pixel with X greater than the X maximum, or Y greater than the Y maximum, produces no output. A pixel with X or Y equal to its maximum is kept.
- R6: A pixel with negative X or negative Y produces no output.
- R7: After reset, outValid is 0 and inReady is 1. The origin, pitch and both maxima are 0 and the depth is 8 bits per pixel. In this state only pixel (0,0) is written, at address 0.
- R8: While outValid is 1 and outReady is 0, inReady is 0 and outAddr, outBitSel and outColor hold their values. While outReady stays 1, one pixel is accepted and one result is issued every clock.
- R9: Surviving pixels leave in the order they were accepted. Each result is valid on the second rising edge after its input handshake.
- R10: A write with cfgWe high loads the register chosen by cfgSel. Selector 0 loads the origin from cfgData[23:0]. Selector 1 loads the pitch from cfgData[11:0]. Selector 2 loads the X maximum from cfgData[11:0] and the Y maximum from cfgData[23:12]. Selector 3 loads the depth from cfgData[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Configuration register selector |
| cfgData | input | 24 | Configuration write data |
| inValid | input | 1 | Pixel command valid |
| inReady | output | 1 | Pixel command accepted when high with inValid |
| inX | input | 12 | Signed X coordinate |
| inY | input | 12 | Signed Y coordinate |
| inColor | input | 8 | Pixel colour |
| outValid | output | 1 | Write request valid |
| outReady | input | 1 | Write request taken when high with outValid |
| outAddr | output | 32 | Word-aligned byte address |
| outBitSel | output | 4 | Bit position of the pixel inside the 16-bit word |
| outColor | output | 8 | Pixel colour |

## Verification
The hardest situation to reach is a stall that lands while both pipeline stages hold pixels, with some of the queued commands being clipped ones that must vanish without creating a gap or a duplicate. The bench sweeps coordinates across and beyond the clip window at both depths. At the same time it drops outReady on a fixed rhythm, so stalls fall on every mix of kept and dropped pixels. A scoreboard ordered by acceptance catches any output that should not exist, any output that is lost, and any change of an output during a stall.

// File: rtl/pag_pkg.sv
package pag_pkg;

  // Strobes the control sends to the datapath for each pipeline stage.
  typedef struct packed {
    logic s1Load;   // capture a kept pixel into stage 1
    logic s2Load;   // move stage 1 into the output stage
  } pag_strobe_t;

  // Selector codes of the configuration port.
  typedef enum logic [1:0] {
    CFG_BASE  = 2'd0,
    CFG_PITCH = 2'd1,
    CFG_LIMIT = 2'd2,
    CFG_DEPTH = 2'd3
  } pag_cfg_sel_e;

endpackage

// File: rtl/pag_cfg_regs.sv
module pag_cfg_regs
  import pag_pkg::*;
#(
  parameter int BASE_W  = 24,
  parameter int COORD_W = 12,
  parameter int PITCH_W = 12,
  parameter int DATA_W  = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfgWe,
  input  logic [1:0]         cfgSel,
  input  logic [DATA_W-1:0]  cfgData,
  output logic [BASE_W-1:0]  baseReg,
  output logic [PITCH_W-1:0] pitchReg,
  output logic [COORD_W-1:0] maxXReg,
  output logic [COORD_W-1:0] maxYReg,
  output logic               depth4Reg
);

  always_ff @(posedge clk) begin
    if (rst) begin
      baseReg   <= '0;
      pitchReg  <= '0;
      maxXReg   <= '0;
      maxYReg   <= '0;
      depth4Reg <= 1'b0;
    end else if (cfgWe) begin
      case (pag_cfg_sel_e'(cfgSel))
        CFG_BASE:  baseReg   <= cfgData[BASE_W-1:0];
        CFG_PITCH: pitchReg  <= cfgData[PITCH_W-1:0];
        CFG_LIMIT: begin
          maxXReg <= cfgData[COORD_W-1:0];
          maxYReg <= cfgData[2*COORD_W-1:COORD_W];
        end
        CFG_DEPTH: depth4Reg <= cfgData[0];
        default: ;
      endcase
    end
  end

  // R7: the first cycle after reset sees cleared registers
  a_r7_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (baseReg == '0 && pitchReg == '0 && maxXReg == '0 &&
                    maxYReg == '0 && !depth4Reg))
    else $error("a_r7_reset_clear");

endmodule

// File: rtl/pag_ctrl.sv
module pag_ctrl
  import pag_pkg::*;
#(
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [COORD_W-1:0] inX,
  input  logic [COORD_W-1:0] inY,
  input  logic [COORD_W-1:0] maxX,
  input  logic [COORD_W-1:0] maxY,
  input  logic               outReady,
  output logic               inReady,
  output logic               outValid,
  output pag_strobe_t        strobe
);

  logic s1Valid;
  logic s2Valid;
  logic advance;
  logic xNeg, yNeg, xOver, yOver, clipped, keep;

  assign xNeg    = inX[COORD_W-1];
  assign yNeg    = inY[COORD_W-1];
  assign xOver   = {1'b0, inX[COORD_W-2:0]} > maxX;
  assign yOver   = {1'b0, inY[COORD_W-2:0]} > maxY;
  assign clipped = xNeg | yNeg | xOver | yOver;
  assign keep    = inValid & ~clipped;

  // The whole pipeline moves when the output slot is free or being drained.
  assign advance  = ~s2Valid | outReady;
  assign inReady  = advance;
  assign outValid = s2Valid;

  always_comb begin
    strobe.s1Load = advance & keep;
    strobe.s2Load = advance & s1Valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
    end else if (advance) begin
      s1Valid <= keep;
      s2Valid <= s1Valid;
    end
  end

  // R5: a pixel beyond either maximum leaves stage 1 empty
  a_r5_clip_over: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady && !inX[COORD_W-1] && !inY[COORD_W-1] &&
     (({1'b0, inX[COORD_W-2:0]} > maxX) || ({1'b0, inY[COORD_W-2:0]} > maxY)))
    |=> !s1Valid)
    else $error("a_r5_clip_over");

  // R6: a negative coordinate leaves stage 1 empty
  a_r6_clip_neg: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady && (inX[COORD_W-1] || inY[COORD_W-1])) |=> !s1Valid)
    else $error("a_r6_clip_neg");

  // R8: no input is taken while the output is blocked
  a_r8_backpressure: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |-> !inReady)
    else $error("a_r8_backpressure");

  // R9: a stage-1 pixel reaches the output on the next advancing edge
  a_r9_stage_move: assert property (@(posedge clk) disable iff (rst)
    (s1Valid && (!outValid || outReady)) |=> outValid)
    else $error("a_r9_stage_move");

endmodule

// File: rtl/pag_datapath.sv
module pag_datapath
  import pag_pkg::*;
#(
  parameter int BASE_W     = 24,
  parameter int BASE_SHIFT = 8,
  parameter int MAG_W      = 11,
  parameter int PITCH_W    = 12,
  parameter int ADDR_W     = 32,
  parameter int COLOR_W    = 8
) (
  input  logic               clk,
  input  pag_strobe_t        strobe,
  input  logic [MAG_W-1:0]   xMag,
  input  logic [MAG_W-1:0]   yMag,
  input  logic [COLOR_W-1:0] inColor,
  input  logic [BASE_W-1:0]  baseReg,
  input  logic [PITCH_W-1:0] pitchReg,
  input  logic               depth4Reg,
  output logic [ADDR_W-1:0]  outAddr,
  output logic [3:0]         outBitSel,
  output logic [COLOR_W-1:0] outColor
);

  localparam int PROD_W = MAG_W + PITCH_W;
  localparam int PIX_W  = PROD_W + 1;
  localparam int OFF_W  = PIX_W + 3;

  // Stage 1: row product and captured configuration
  logic [PROD_W-1:0]  rowR;
  logic [MAG_W-1:0]   xR;
  logic [BASE_W-1:0]  baseR;
  logic               depth4R;
  logic [COLOR_W-1:0] colorR;

  always_ff @(posedge clk) begin
    if (strobe.s1Load) begin
      rowR    <= PROD_W'(yMag) * PROD_W'(pitchReg);
      xR      <= xMag;
      baseR   <= baseReg;
      depth4R <= depth4Reg;
      colorR  <= inColor;
    end
  end

  // Stage 2: pixel index, bit offset, byte address
  logic [PIX_W-1:0]  pixIdx;
  logic [OFF_W-1:0]  bitOff;
  logic [ADDR_W-1:0] originByte;
  logic [ADDR_W-1:0] byteAddr;

  always_comb begin
    pixIdx     = PIX_W'(rowR) + PIX_W'(xR);
    bitOff     = depth4R ? {1'b0, pixIdx, 2'b00} : {pixIdx, 3'b000};
    originByte = ADDR_W'({baseR, {BASE_SHIFT{1'b0}}});
    byteAddr   = originByte + ADDR_W'(bitOff[OFF_W-1:3]);
  end

  always_ff @(posedge clk) begin
    if (strobe.s2Load) begin
      outAddr   <= byteAddr & ~ADDR_W'(1);
      outBitSel <= bitOff[3:0];
      outColor  <= colorR;
    end
  end

endmodule

// File: rtl/pixel_addr_gen.sv
module pixel_addr_gen
  import pag_pkg::*;
#(
  parameter int BASE_W     = 24,
  parameter int BASE_SHIFT = 8,
  parameter int COORD_W    = 12,
  parameter int PITCH_W    = 12,
  parameter int ADDR_W     = 32,
  parameter int COLOR_W    = 8,
  parameter int DATA_W     = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfgWe,
  input  logic [1:0]         cfgSel,
  input  logic [DATA_W-1:0]  cfgData,
  input  logic               inValid,
  output logic               inReady,
  input  logic [COORD_W-1:0] inX,
  input  logic [COORD_W-1:0] inY,
  input  logic [COLOR_W-1:0] inColor,
  output logic               outValid,
  input  logic               outReady,
  output logic [ADDR_W-1:0]  outAddr,
  output logic [3:0]         outBitSel,
  output logic [COLOR_W-1:0] outColor
);

  localparam int MAG_W = COORD_W - 1;

  logic [BASE_W-1:0]  baseReg;
  logic [PITCH_W-1:0] pitchReg;
  logic [COORD_W-1:0] maxXReg, maxYReg;
  logic               depth4Reg;
  pag_strobe_t        strobe;

  pag_cfg_regs #(
    .BASE_W(BASE_W), .COORD_W(COORD_W), .PITCH_W(PITCH_W), .DATA_W(DATA_W)
  ) uCfg (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .baseReg(baseReg), .pitchReg(pitchReg), .maxXReg(maxXReg),
    .maxYReg(maxYReg), .depth4Reg(depth4Reg)
  );

  pag_ctrl #(.COORD_W(COORD_W)) uCtrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inX(inX), .inY(inY),
    .maxX(maxXReg), .maxY(maxYReg), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .strobe(strobe)
  );

  pag_datapath #(
    .BASE_W(BASE_W), .BASE_SHIFT(BASE_SHIFT), .MAG_W(MAG_W),
    .PITCH_W(PITCH_W), .ADDR_W(ADDR_W), .COLOR_W(COLOR_W)
  ) uData (
    .clk(clk), .strobe(strobe), .xMag(inX[MAG_W-1:0]), .yMag(inY[MAG_W-1:0]),
    .inColor(inColor), .baseReg(baseReg), .pitchReg(pitchReg),
    .depth4Reg(depth4Reg), .outAddr(outAddr), .outBitSel(outBitSel),
    .outColor(outColor)
  );

  // R8: a blocked request holds still
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outAddr) &&
                                 $stable(outBitSel) && $stable(outColor)))
    else $error("a_r8_hold_stable");

  // R4: issued addresses are word aligned
  a_r4_word_align: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !outAddr[0])
    else $error("a_r4_word_align");

endmodule

// File: tb/pixel_addr_gen_test.sv
module pixel_addr_gen_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [23:0] cfgData = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [11:0] inX = '0, inY = '0;
  logic [7:0]  inColor = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [31:0] outAddr;
  logic [3:0]  outBitSel;
  logic [7:0]  outColor;

  pixel_addr_gen uut (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .inValid(inValid), .inReady(inReady), .inX(inX), .inY(inY),
    .inColor(inColor), .outValid(outValid), .outReady(outReady),
    .outAddr(outAddr), .outBitSel(outBitSel), .outColor(outColor)
  );

  always #4 clk = ~clk;   // 125 MHz

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit finished = 0;

  // bench copy of the configuration
  longint curBase = 0, curPitch = 0, curMaxX = 0, curMaxY = 0;
  bit curD4 = 0;

  logic [31:0] qAddr[$];
  logic [3:0]  qSel[$];
  logic [7:0]  qCol[$];
  string       qTag[$];

  bit stallMode = 0;
  bit burstOn = 0;
  int tick = 0;
  int lastPop = -1;
  int burstPops = 0;
  int burstGapErr = 0;
  bit holdPending = 0;
  logic [31:0] heldAddr;
  logic [3:0]  heldSel;
  logic [7:0]  heldCol;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
      finishRun();
    end
  end

  // Output monitor: decides outReady at each falling edge and checks results.
  always @(negedge clk) begin
    bit newReady;
    if (!rst) begin
      newReady = stallMode ? ((tick % 3) != 0) : 1'b1;
      tick++;
      if (holdPending) begin
        check(outValid === 1'b1 && outAddr === heldAddr && outBitSel === heldSel &&
              outColor === heldCol, "R8", "held request", outAddr, heldAddr);
        check(inReady === 1'b0, "R8", "inReady during stall", inReady, 0);
        holdPending = 0;
      end
      if (outValid && !newReady) begin
        holdPending = 1;
        heldAddr = outAddr; heldSel = outBitSel; heldCol = outColor;
      end
      if (outValid === 1'b1 && newReady) begin
        if (qAddr.size() == 0) begin
          check(0, "R5", "unexpected output", outAddr, 0);
        end else begin
          logic [31:0] ea; logic [3:0] es; logic [7:0] ec; string tg;
          ea = qAddr.pop_front(); es = qSel.pop_front();
          ec = qCol.pop_front(); tg = qTag.pop_front();
          check(outAddr === ea, tg, "address", outAddr, ea);
          check(outBitSel === es, "R4", "bit select", outBitSel, es);
          check(outColor === ec, "R2", "colour", outColor, ec);
        end
        if (burstOn) begin
          if (lastPop >= 0 && tick - lastPop != 1) burstGapErr++;
          lastPop = tick;
          burstPops++;
        end
      end
      outReady = newReady;
    end
  end

  task automatic writeCfg(logic [1:0] sel, logic [23:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgData = data;
    @(posedge clk); #1;
    cfgWe = 1'b0;
  endtask

  task automatic setup(longint base, longint pitch, longint mx, longint my, bit d4);
    writeCfg(2'd0, 24'(base));
    writeCfg(2'd1, 24'(pitch));
    writeCfg(2'd2, {12'(my), 12'(mx)});
    writeCfg(2'd3, {23'd0, d4});
    curBase = base; curPitch = pitch; curMaxX = mx; curMaxY = my; curD4 = d4;
  endtask

  task automatic sendPix(int x, int y, string tag);
    logic [7:0] col;
    col = 8'((x * 7 + y * 3 + 5) & 255);
    @(negedge clk);
    inValid = 1'b1; inX = 12'(x); inY = 12'(y); inColor = col;
    #1;
    while (inReady !== 1'b1) begin
      @(negedge clk); #1;
    end
    if (x >= 0 && y >= 0 && x <= curMaxX && y <= curMaxY) begin
      longint idx, bits, byteA;
      idx   = longint'(y) * curPitch + longint'(x);
      bits  = idx * (curD4 ? 4 : 8);
      byteA = curBase * 256 + bits / 8;
      qAddr.push_back(32'(byteA) & 32'hFFFF_FFFE);
      qSel.push_back(4'(bits % 16));
      qCol.push_back(col);
      qTag.push_back(tag);
    end
    @(posedge clk); #1;
    inValid = 1'b0;
  endtask

  task automatic drain(string tag);
    int n = 0;
    while (qAddr.size() != 0 && n < 200) begin
      @(negedge clk); n++;
    end
    repeat (4) @(negedge clk);
    check(qAddr.size() == 0, tag, "results still owed", qAddr.size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R7: reset state at the ports
    check(outValid === 1'b0, "R7", "outValid after reset", outValid, 0);
    check(inReady === 1'b1, "R7", "inReady after reset", inReady, 1);
    // R7: cleared limits let only the origin through, at address 0
    sendPix(1, 0, "R7");
    sendPix(0, 0, "R7");
    sendPix(0, 1, "R7");
    sendPix(-1, 0, "R6");
    drain("R7");

    // R2 R5 R6 R10: 8 bpp sweep across the clip edges, with stalls
    setup(64'h123456, 20, 13, 6, 0);
    stallMode = 1;
    for (int y = -2; y <= 8; y++)
      for (int x = -2; x <= 15; x++)
        sendPix(x, y, "R2");
    drain("R5");

    // R3 R4: 4 bpp sweep with an odd pitch, with stalls
    setup(64'h000042, 21, 20, 5, 1);
    for (int y = -2; y <= 7; y++)
      for (int x = -2; x <= 22; x++)
        sendPix(x, y, "R3");
    drain("R3");
    stallMode = 0;

    // R1: large coordinates and an origin above 2^20
    setup(64'h100000, 2000, 2047, 2047, 0);
    sendPix(2047, 2047, "R1");
    sendPix(0, 2047, "R1");
    sendPix(2047, 0, "R1");
    sendPix(-2048, 5, "R6");
    sendPix(5, -1, "R6");
    drain("R1");
    setup(64'hFFFFF0, 4095, 2047, 2047, 1);
    sendPix(2047, 2047, "R1");
    sendPix(1, 0, "R1");
    sendPix(3, 9, "R1");
    drain("R1");

    // R8 R9: back-to-back burst, one result per clock in order
    setup(64'h000200, 16, 15, 15, 0);
    burstOn = 1;
    for (int i = 0; i < 8; i++) sendPix(i, i, "R9");
    drain("R9");
    burstOn = 0;
    check(burstPops == 8, "R8", "burst result count", burstPops, 8);
    check(burstGapErr == 0, "R8", "burst gaps", burstGapErr, 0);

    finishRun();
  end

endmodule